// File: doc/BRIEF.md
# Packet-Command Task-File Device Engine

This block is the device end of a parallel-disk task-file interface with packet support. A host reaches eight byte-wide registers and one 16-bit data port over a simple synchronous bus: a 3-bit address, separate write and read strobes, 16-bit write data, and read data that follows the address in the same cycle. Each strobe acts on the rising clock edge of the cycle in which it is high. A write to the command location starts one of two actions. A device-reset code restores a fixed signature in the task file. A packet code opens a write window that collects a short command packet, one 16-bit word per data write.

When the last word of the packet arrives, the block decodes the packet's first byte. If it is the identify opcode, the block takes the length the host asked for, caps it at the size of a built-in identification table, and places that byte count in the two upper address registers. It then opens a read window, and the host drains the table through the data port. Any other command or opcode only marks the device ready and opens no window.

Top module: `pio_tf_device`

## Requirements
- R1: After `rst_n` is released, reads return error 0x01, count 0x01, addr-low 0x21, addr-mid 0x14, addr-high 0xEB, device 0x00, status 0x00. The read map is 1 error, 2 count, 3 addr-low, 4 addr-mid, 5 addr-high, 6 device, 7 status. Register values sit in bits 7:0 and bits 15:8 read as zero.
- R2: Writing 0x08 to address 7 restores the R1 register values, closes any open data window and leaves status 0x50.
- R3: Every write to address 7 sets status bit 6 (ready) and bit 4 (service). Status bit 7 (busy) always reads 0. A code other than 0x08 or 0xA0 changes no other register and opens no window.
- R4: Writing 0xA0 to address 7 opens a 12-byte packet window and sets status bit 3 (data request). The window closes after exactly six data writes to address 0.
- R5: A data write to address 0 while no window is open changes no register and no status bit.
- R6: A data read from address 0 while no read window is open returns 0xFFFF and changes nothing.
- R7: The packet opcode is the low byte of the first packet word. If it equals ID_OPCODE (default 0x11), the requested length is the whole second word: bits 7:0 hold packet byte 2 and bits 15:8 hold byte 3. The length is capped at 32. The capped value's low byte goes to address 4 and its high byte to address 5, and status bit 3 stays set.
- R8: Read-window words come from a 32-byte table in which byte i is (ID_SEED + 7*i) mod 256, with ID_SEED defaulting to 0x5A. Word k is returned as {byte 2k+1, byte 2k}.
- R9: A read window of L bytes delivers ceil(L/2) words, and one word when L is 0. After the last word, status bit 3 clears and further reads return 0xFFFF.
- R10: A completed packet whose opcode is not ID_OPCODE opens no read window, clears status bit 3 and leaves every readable register unchanged.
- R11: Host writes to addresses 2 to 6 land in count, addr-low, addr-mid, addr-high and device, and read back unchanged. A write to address 1 never changes the error value read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register select |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 16 | Write data; register writes use bits 7:0 |
| host_rdata | output | 16 | Read data for the current address |

## Verification
Packets are sent with random opcodes, half of them the identify code. The requested lengths are random from zero to beyond the table size, plus the directed values 0, 1, 31, 32, 33, 0x0100 and 0xFFFF. Together these separate three behaviours: the cap, rounding up to whole words, and the one-word minimum. The 0x0100 case shows whether the high length byte takes part in the compare. Stray data reads and writes, unknown command codes and random register writes are mixed in between packets, so a leak of state between transactions shows up in later reads. A device reset in the middle of a packet checks that an open window is dropped.

// File: rtl/pio_tf_pkg.sv
package pio_tf_pkg;

   localparam logic [2:0] A_DATA    = 3'd0;
   localparam logic [2:0] A_ERRFEAT = 3'd1;
   localparam logic [2:0] A_COUNT   = 3'd2;
   localparam logic [2:0] A_LBA0    = 3'd3;
   localparam logic [2:0] A_LBA1    = 3'd4;
   localparam logic [2:0] A_LBA2    = 3'd5;
   localparam logic [2:0] A_DEV     = 3'd6;
   localparam logic [2:0] A_STATCMD = 3'd7;

   localparam int ST_BSY  = 7;
   localparam int ST_DRDY = 6;
   localparam int ST_SERV = 4;
   localparam int ST_DRQ  = 3;

   typedef enum logic [1:0] {
      WIN_IDLE   = 2'd0,
      WIN_PACKET = 2'd1,
      WIN_IDENT  = 2'd2
   } win_mode_e;

   typedef struct packed {
      logic [7:0] err;
      logic [7:0] feat;
      logic [7:0] count;
      logic [7:0] lba0;
      logic [7:0] lba1;
      logic [7:0] lba2;
      logic [7:0] dev;
   } tf_regs_t;

   function automatic tf_regs_t tf_signature();
      tf_regs_t s;
      s.err   = 8'h01;
      s.feat  = 8'h00;
      s.count = 8'h01;
      s.lba0  = 8'h21;
      s.lba1  = 8'h14;
      s.lba2  = 8'hEB;
      s.dev   = 8'h00;
      return s;
   endfunction

   function automatic logic [7:0] id_byte(input logic [7:0] seed, input int unsigned idx);
      return seed + 8'(idx * 7);
   endfunction

endpackage

// File: rtl/pio_tf_idrom.sv
module pio_tf_idrom #(
   parameter int         ID_BYTES = 32,
   parameter logic [7:0] SEED     = 8'h5A,
   parameter int         IDX_W    = 4
) (
   input  logic [IDX_W-1:0] word_idx,
   output logic [15:0]      word_o
);
   localparam int WORDS = ID_BYTES / 2;

   logic [15:0] rom [WORDS];

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      assign rom[k] = {pio_tf_pkg::id_byte(SEED, 2 * k + 1),
                       pio_tf_pkg::id_byte(SEED, 2 * k)};
   end

   assign word_o = rom[word_idx];

endmodule

// File: rtl/pio_tf_window.sv
module pio_tf_window
   import pio_tf_pkg::*;
#(
   parameter int PKT_BYTES = 12,
   parameter int ID_BYTES  = 32,
   parameter int RI_W      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            open_pkt,
   input  logic            data_wr,
   input  logic            data_rd,
   input  logic [15:0]     wdata,
   input  logic            start_ident,
   input  logic [15:0]     ident_len,
   output logic            drq,
   output logic            rd_active,
   output logic            pkt_last,
   output logic [RI_W-1:0] rd_idx,
   output logic [7:0]      pkt_op,
   output logic [15:0]     pkt_len
);
   localparam int PKT_WORDS = PKT_BYTES / 2;
   localparam int PW_W      = $clog2(PKT_WORDS);
   localparam int MAXB      = (PKT_BYTES > ID_BYTES) ? PKT_BYTES : ID_BYTES;
   localparam int CNT_W     = $clog2(MAXB + 1) + 2;
   localparam logic signed [CNT_W-1:0] TWO     = CNT_W'(2);
   localparam logic signed [CNT_W-1:0] PKT_LEN = CNT_W'(PKT_BYTES);

   win_mode_e                 mode_q;
   logic signed [CNT_W-1:0]   left_q;
   logic [PW_W-1:0]           wptr_q;
   logic [RI_W-1:0]           rptr_q;
   logic [7:0]                op_q;
   logic [15:0]               len_q;
   logic                      take_wr;
   logic                      take_rd;
   logic                      final_beat;

   assign take_wr    = data_wr && (mode_q == WIN_PACKET);
   assign take_rd    = data_rd && (mode_q == WIN_IDENT);
   assign final_beat = (left_q <= TWO);
   assign pkt_last   = take_wr && final_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= WIN_IDLE;
         left_q <= '0;
         wptr_q <= '0;
         rptr_q <= '0;
      end else if (flush) begin
         mode_q <= WIN_IDLE;
      end else if (open_pkt) begin
         mode_q <= WIN_PACKET;
         left_q <= PKT_LEN;
         wptr_q <= '0;
      end else if (take_wr) begin
         wptr_q <= wptr_q + 1'b1;
         left_q <= left_q - TWO;
         if (final_beat) begin
            if (start_ident) begin
               mode_q <= WIN_IDENT;
               left_q <= $signed(CNT_W'(ident_len));
               rptr_q <= '0;
            end else begin
               mode_q <= WIN_IDLE;
            end
         end
      end else if (take_rd) begin
         rptr_q <= rptr_q + 1'b1;
         left_q <= left_q - TWO;
         if (final_beat) mode_q <= WIN_IDLE;
      end
   end

   // Only the opcode and the length word are kept; later packet words are counted.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= '0;
         len_q <= '0;
      end else if (take_wr) begin
         if (wptr_q == PW_W'(0)) op_q  <= wdata[7:0];
         if (wptr_q == PW_W'(1)) len_q <= wdata;
      end
   end

   assign drq       = (mode_q != WIN_IDLE);
   assign rd_active = (mode_q == WIN_IDENT);
   assign rd_idx    = rptr_q;
   assign pkt_op    = op_q;
   assign pkt_len   = len_q;

endmodule

// File: rtl/pio_tf_dispatch.sv
module pio_tf_dispatch #(
   parameter int         ID_BYTES  = 32,
   parameter logic [7:0] ID_OPCODE = 8'h11
) (
   input  logic [7:0]  pkt_op,
   input  logic [15:0] pkt_len,
   output logic        is_ident,
   output logic [15:0] ident_len
);
   localparam logic [15:0] CAP = 16'(ID_BYTES);

   assign is_ident  = (pkt_op == ID_OPCODE);
   assign ident_len = (pkt_len > CAP) ? CAP : pkt_len;

endmodule

// File: rtl/pio_tf_regs.sv
module pio_tf_regs
   import pio_tf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  addr,
   input  logic [7:0]  wbyte,
   input  logic        cmd_wr,
   input  logic        dev_reset,
   input  logic        load_len,
   input  logic [15:0] len,
   output tf_regs_t    tf,
   output logic        drdy,
   output logic        serv
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tf   <= tf_signature();
         drdy <= 1'b0;
         serv <= 1'b0;
      end else begin
         if (dev_reset) begin
            tf <= tf_signature();
         end else begin
            if (reg_wr) begin
               case (addr)
                  A_ERRFEAT: tf.feat  <= wbyte;
                  A_COUNT:   tf.count <= wbyte;
                  A_LBA0:    tf.lba0  <= wbyte;
                  A_LBA1:    tf.lba1  <= wbyte;
                  A_LBA2:    tf.lba2  <= wbyte;
                  A_DEV:     tf.dev   <= wbyte;
                  default:   ;
               endcase
            end
            if (load_len) begin
               tf.lba1 <= len[7:0];
               tf.lba2 <= len[15:8];
            end
         end
         if (cmd_wr) begin
            drdy <= 1'b1;
            serv <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pio_tf_device.sv
module pio_tf_device
   import pio_tf_pkg::*;
#(
   parameter int         PKT_BYTES    = 12,
   parameter int         ID_BYTES     = 32,
   parameter logic [7:0] ID_OPCODE    = 8'h11,
   parameter logic [7:0] ID_SEED      = 8'h5A,
   parameter logic [7:0] CMD_DEVRESET = 8'h08,
   parameter logic [7:0] CMD_PACKET   = 8'hA0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  host_addr,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic [15:0] host_wdata,
   output logic [15:0] host_rdata
);
   localparam int ID_WORDS = ID_BYTES / 2;
   localparam int RI_W     = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;

   if (PKT_BYTES < 6 || (PKT_BYTES % 2) != 0) begin : g_bad_pkt
      $error("PKT_BYTES must be even and at least 6");
   end
   if (ID_BYTES < 2 || ID_BYTES > 255 || (ID_WORDS & (ID_WORDS - 1)) != 0) begin : g_bad_id
      $error("ID_BYTES must give a power-of-two word count and fit in one byte");
   end
   if (CMD_DEVRESET == CMD_PACKET) begin : g_bad_cmd
      $error("command codes must differ");
   end

   logic            cmd_wr, dev_reset, open_pkt, data_wr, data_rd, reg_wr;
   logic            drq, rd_active, pkt_last, is_ident, load_len;
   logic            drdy, serv;
   logic [RI_W-1:0] rd_idx;
   logic [7:0]      pkt_op;
   logic [15:0]     pkt_len, ident_len, rom_word;
   logic [7:0]      status_b;
   tf_regs_t        tf_q;

   assign cmd_wr    = host_wr && (host_addr == A_STATCMD);
   assign dev_reset = cmd_wr && (host_wdata[7:0] == CMD_DEVRESET);
   assign open_pkt  = cmd_wr && (host_wdata[7:0] == CMD_PACKET);
   assign data_wr   = host_wr && (host_addr == A_DATA);
   assign data_rd   = host_rd && (host_addr == A_DATA);
   assign reg_wr    = host_wr && (host_addr != A_DATA) && (host_addr != A_STATCMD);
   assign load_len  = pkt_last && is_ident;

   pio_tf_window #(
      .PKT_BYTES (PKT_BYTES),
      .ID_BYTES  (ID_BYTES),
      .RI_W      (RI_W)
   ) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (dev_reset),
      .open_pkt    (open_pkt),
      .data_wr     (data_wr),
      .data_rd     (data_rd),
      .wdata       (host_wdata),
      .start_ident (is_ident),
      .ident_len   (ident_len),
      .drq         (drq),
      .rd_active   (rd_active),
      .pkt_last    (pkt_last),
      .rd_idx      (rd_idx),
      .pkt_op      (pkt_op),
      .pkt_len     (pkt_len)
   );

   pio_tf_dispatch #(
      .ID_BYTES  (ID_BYTES),
      .ID_OPCODE (ID_OPCODE)
   ) u_disp (
      .pkt_op    (pkt_op),
      .pkt_len   (pkt_len),
      .is_ident  (is_ident),
      .ident_len (ident_len)
   );

   pio_tf_idrom #(
      .ID_BYTES (ID_BYTES),
      .SEED     (ID_SEED),
      .IDX_W    (RI_W)
   ) u_rom (
      .word_idx (rd_idx),
      .word_o   (rom_word)
   );

   pio_tf_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .addr      (host_addr),
      .wbyte     (host_wdata[7:0]),
      .cmd_wr    (cmd_wr),
      .dev_reset (dev_reset),
      .load_len  (load_len),
      .len       (ident_len),
      .tf        (tf_q),
      .drdy      (drdy),
      .serv      (serv)
   );

   always_comb begin
      status_b          = '0;
      status_b[ST_BSY]  = 1'b0;
      status_b[ST_DRDY] = drdy;
      status_b[ST_SERV] = serv;
      status_b[ST_DRQ]  = drq;
   end

   always_comb begin
      case (host_addr)
         A_DATA:    host_rdata = rd_active ? rom_word : 16'hFFFF;
         A_ERRFEAT: host_rdata = {8'h00, tf_q.err};
         A_COUNT:   host_rdata = {8'h00, tf_q.count};
         A_LBA0:    host_rdata = {8'h00, tf_q.lba0};
         A_LBA1:    host_rdata = {8'h00, tf_q.lba1};
         A_LBA2:    host_rdata = {8'h00, tf_q.lba2};
         A_DEV:     host_rdata = {8'h00, tf_q.dev};
         default:   host_rdata = {8'h00, status_b};
      endcase
   end

endmodule

// File: rtl/pio_tf_checker.sv
module pio_tf_checker
   import pio_tf_pkg::*;
#(
   parameter int         ID_BYTES     = 32,
   parameter logic [7:0] CMD_DEVRESET = 8'h08,
   parameter logic [7:0] CMD_PACKET   = 8'hA0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  host_addr,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic [15:0] host_wdata,
   input  logic [15:0] host_rdata,
   input  logic [7:0]  status_b,
   input  logic        rd_active,
   input  tf_regs_t    tf
);
   logic cmd_w;
   assign cmd_w = host_wr && (host_addr == A_STATCMD);

   p_devreset_sig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && host_wdata[7:0] == CMD_DEVRESET) |=>
         (tf.err == 8'h01 && tf.count == 8'h01 && tf.lba0 == 8'h21 &&
          tf.lba1 == 8'h14 && tf.lba2 == 8'hEB && tf.dev == 8'h00 && status_b == 8'h50));

   p_cmd_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_w |=> (status_b[ST_DRDY] && status_b[ST_SERV]));

   p_unknown_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && host_wdata[7:0] != CMD_DEVRESET && host_wdata[7:0] != CMD_PACKET) |=>
         ($stable(tf) && status_b[ST_DRQ] == $past(status_b[ST_DRQ])));

   p_pkt_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && host_wdata[7:0] == CMD_PACKET) |=> status_b[ST_DRQ]);

   p_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == A_DATA && !status_b[ST_DRQ]) |=>
         ($stable(tf) && $stable(status_b)));

   p_idle_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == A_DATA && !status_b[ST_DRQ]) |-> host_rdata == 16'hFFFF);

   p_len_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_active) |-> (tf.lba1 <= 8'(ID_BYTES) && tf.lba2 == 8'h00 && status_b[ST_DRQ]));

endmodule

bind pio_tf_device pio_tf_checker #(
   .ID_BYTES     (ID_BYTES),
   .CMD_DEVRESET (CMD_DEVRESET),
   .CMD_PACKET   (CMD_PACKET)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .status_b   (status_b),
   .rd_active  (rd_active),
   .tf         (tf_q)
);

// File: tb/pio_tf_device_test.sv
module pio_tf_device_test;
   localparam logic [7:0] ID_OPC = 8'h11;
   localparam logic [7:0] SEED   = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [7:0] m_err, m_cnt, m_l0, m_l1, m_l2, m_dev;
   bit         m_rdy;

   always #4 clk = ~clk;

   pio_tf_device uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata));

   function automatic logic [7:0] idb(int i);
      return SEED + 8'(i * 7);
   endfunction

   function automatic logic [15:0] idw(int k);
      return {idb(2 * k + 1), idb(2 * k)};
   endfunction

   function automatic int clamp_len(int req);
      return (req > 32) ? 32 : req;
   endfunction

   function automatic int words_for(int len);
      return (len == 0) ? 1 : (len + 1) / 2;
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   task automatic bus_rd(logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(posedge clk); #1;
      host_rd = 1'b0;
   endtask

   task automatic chk_rd(string req, logic [2:0] a, logic [15:0] exp);
      logic [15:0] d;
      bus_rd(a, d);
      check(req, d, exp);
   endtask

   task automatic model_sig();
      m_err = 8'h01; m_cnt = 8'h01; m_l0 = 8'h21; m_l1 = 8'h14; m_l2 = 8'hEB; m_dev = 8'h00;
   endtask

   task automatic chk_all(string req);
      chk_rd(req, 3'd1, {8'h00, m_err});
      chk_rd(req, 3'd2, {8'h00, m_cnt});
      chk_rd(req, 3'd3, {8'h00, m_l0});
      chk_rd(req, 3'd4, {8'h00, m_l1});
      chk_rd(req, 3'd5, {8'h00, m_l2});
      chk_rd(req, 3'd6, {8'h00, m_dev});
      chk_rd(req, 3'd7, m_rdy ? 16'h0050 : 16'h0000);
   endtask

   task automatic run_packet(logic [7:0] op, logic [15:0] req_len);
      bus_wr(3'd7, 16'h00A0);
      m_rdy = 1'b1;
      chk_rd("R4 packet window open", 3'd7, 16'h0058);
      bus_wr(3'd0, {8'($urandom_range(255)), op});
      bus_wr(3'd0, req_len);
      for (int i = 2; i < 5; i++) begin
         bus_wr(3'd0, 16'($urandom));
         chk_rd("R4 window still open", 3'd7, 16'h0058);
      end
      bus_wr(3'd0, 16'($urandom));
      if (op == ID_OPC) begin
         int len = clamp_len(int'(req_len));
         m_l1 = 8'(len); m_l2 = 8'(len >> 8);
         chk_rd("R7 read window drq", 3'd7, 16'h0058);
         chk_rd("R7 length low", 3'd4, {8'h00, m_l1});
         chk_rd("R7 length high", 3'd5, {8'h00, m_l2});
         for (int k = 0; k < words_for(len); k++)
            chk_rd("R8 id word", 3'd0, idw(k));
         chk_rd("R9 drq clears", 3'd7, 16'h0050);
         chk_rd("R9 read after end", 3'd0, 16'hFFFF);
      end else begin
         chk_all("R10 non-identify packet");
         chk_rd("R10 no read window", 3'd0, 16'hFFFF);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      model_sig(); m_rdy = 1'b0;

      chk_all("R1 reset values");
      chk_rd("R6 idle read", 3'd0, 16'hFFFF);
      chk_all("R6 idle read no effect");

      bus_wr(3'd0, 16'h1234);
      chk_all("R5 stray write");

      bus_wr(3'd7, 16'h00EC);
      m_rdy = 1'b1;
      chk_all("R3 unknown command");

      bus_wr(3'd1, 16'h00FF);
      chk_rd("R11 error read-only", 3'd1, 16'h0001);
      bus_wr(3'd2, 16'hAA33); m_cnt = 8'h33;
      bus_wr(3'd6, 16'h00A0); m_dev = 8'hA0;
      chk_all("R11 register write back");

      bus_wr(3'd7, 16'h0008);
      model_sig();
      chk_all("R2 device reset");

      run_packet(ID_OPC, 16'd0);
      run_packet(ID_OPC, 16'd1);
      run_packet(ID_OPC, 16'd31);
      run_packet(ID_OPC, 16'd32);
      run_packet(ID_OPC, 16'd33);
      run_packet(ID_OPC, 16'h0100);
      run_packet(ID_OPC, 16'hFFFF);
      run_packet(8'h12, 16'd8);

      bus_wr(3'd7, 16'h00A0);
      bus_wr(3'd0, {8'h00, ID_OPC});
      bus_wr(3'd0, 16'd20);
      bus_wr(3'd7, 16'h0008);
      model_sig();
      chk_all("R2 reset closes window");
      bus_wr(3'd0, 16'h5555);
      chk_all("R2 window gone after reset");
      chk_rd("R2 no data after reset", 3'd0, 16'hFFFF);

      for (int it = 0; it < 300; it++) begin
         case ($urandom_range(6))
            0: begin
               logic [2:0] a = 3'($urandom_range(6, 2));
               logic [7:0] v = 8'($urandom);
               bus_wr(a, {8'($urandom), v});
               case (a)
                  3'd2: m_cnt = v;
                  3'd3: m_l0 = v;
                  3'd4: m_l1 = v;
                  3'd5: m_l2 = v;
                  default: m_dev = v;
               endcase
               chk_rd("R11 random reg", a, {8'h00, v});
            end
            1: chk_all("R11 random readback");
            2: begin
               logic [7:0] op = ($urandom_range(1) == 1) ? ID_OPC : 8'($urandom_range(255));
               run_packet(op, 16'($urandom_range(80)));
            end
            3: begin
               bus_wr(3'd0, 16'($urandom));
               chk_rd("R5 random stray write", 3'd7, m_rdy ? 16'h0050 : 16'h0000);
               chk_rd("R5 random stray write regs", 3'd2, {8'h00, m_cnt});
            end
            4: begin
               bus_rd(3'd0, d);
               check("R6 random idle read", d, 16'hFFFF);
            end
            5: begin
               logic [7:0] c = 8'($urandom);
               if (c == 8'h08 || c == 8'hA0) c = 8'hE0;
               bus_wr(3'd7, {8'h00, c});
               m_rdy = 1'b1;
               chk_all("R3 random unknown command");
            end
            default: begin
               bus_wr(3'd7, 16'h0008);
               model_sig(); m_rdy = 1'b1;
               chk_all("R2 random device reset");
            end
         endcase
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule